// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that gives an external bus master access to a small bank of byte-wide registers. It samples the SCL and SDA lines with the fast system clock and does not need any phase relation between the two. It finds START, repeated START and STOP conditions on the sampled lines and frames bytes on SCL rising edges. Each register also appears on a parallel output, so on-chip logic can read it continuously.

A transaction opens with an address byte. The upper seven bits of that byte are compared with the configured device address, and its least significant bit selects the direction. In a write, the first byte after the address sets an internal register pointer. Each following byte is stored at the pointer, and the pointer then advances. In a read, the target returns the register at the pointer and advances the pointer after every byte. The pointer keeps its value between transactions. A second, local port lets on-chip logic load any register directly in the system clock domain. The block drives SDA through separate pull-down and pull-up enables and never stretches SCL.

The controller is one state machine with these states:
- `ST_IDLE`
- `ST_ADDR` receives the address byte.
- `ST_ADDR_ACK` acknowledges a match.
- `ST_PTR` receives the pointer byte.
- `ST_PTR_ACK` acknowledges the pointer byte.
- `ST_WDATA` receives a write data byte.
- `ST_WDATA_ACK` acknowledges a write data byte.
- `ST_RDATA` shifts out a read byte.
- `ST_RACK` samples the master's acknowledge.
- `ST_IGNORE` stays silent.

Transitions:
- START from any state leads to `ST_ADDR`. STOP from any state leads to `ST_IDLE`.
- From `ST_ADDR`, when the byte is complete at the SCL fall: to `ST_ADDR_ACK` on a match, otherwise to `ST_IGNORE`.
- `ST_ADDR_ACK` leads to `ST_RDATA` for a read and to `ST_PTR` for a write.
- `ST_PTR` leads to `ST_PTR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` leads to `ST_RACK` after eight bits.
- From `ST_RACK`: back to `ST_RDATA` on ACK, and to `ST_IGNORE` on NACK.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0, and `sda_pd`, `sda_pu` and `scl_pd` are all low.
- R2: An address byte whose bits 7..1 equal `dev_addr[7:1]` is acknowledged: SDA is held low during the ninth SCL clock. Bit 0 of the address byte selects a write (0) or a read (1). With `dev_addr` = 0x72, 0x72 writes and 0x73 reads.
- R3: In a write, the first byte after the address loads the pointer from its low bits, which means the byte value modulo the number of registers. Each later byte is stored at the pointer, and the pointer then increments and wraps from 3 to 0. Every such byte is acknowledged.
- R4: In a read, the target sends the register at the pointer MSB first and increments the pointer after each byte. It keeps sending while the master acknowledges, and after a NACK it releases SDA.
- R5: The pointer is not reset between transactions. A read with no pointer byte continues from the register after the last one accessed.
- R6: If the address does not match, the target acknowledges neither that byte nor any later byte, and changes neither the registers nor the pointer, until the next START or STOP.
- R7: When `loc_wr` is high, `loc_data` is stored in the register selected by `loc_addr` and appears on `reg_q` one clock later. Holding the strobe for several cycles gives the same result as holding it for one.
- R8: If a local write and a bus write hit the same register in the same cycle, the local data is kept.
- R9: `sda_pd` and `sda_pu` are never high together. `sda_pu` is high only while a read data bit of value 1 is being sent. `scl_pd` stays low.
- R10: A repeated START restarts byte framing at the address byte. After a STOP the target returns to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| dev_addr | input | DW (8) | Device address byte; bit 0 is not compared |
| loc_wr | input | 1 | Local write strobe |
| loc_addr | input | PTR_W (2) | Local write register index |
| loc_data | input | DW (8) | Local write data |
| scl_pd | output | 1 | SCL pull-down enable (always low) |
| sda_pd | output | 1 | SDA pull-down enable |
| sda_pu | output | 1 | SDA active pull-up enable |
| reg_q | output | NREG*DW (32) | All registers; register k occupies bits k*DW +: DW |

## Verification
A bus write and a local write can land in the same clock cycle. This happens when the eighth SCL fall of a write data byte arrives while `loc_wr` is active.

The bench provokes the collision in two steps. It first raises the local strobe for a register and holds it. It then sends a bus write whose pointer runs through that same register, so the collision cycle falls inside the hold window no matter how synchronizer latency shifts it.

The reference model pins the register to the local value and still advances its pointer. The result is judged every clock on `reg_q`, and again by a later bus read. That read also shows that the next register received the following bus byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchronizer for one bus line, with level and edge outputs.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic [STAGES:0]   feed;
    logic              prev_q;

    assign feed = {sh, line_in};

    // Bus lines idle high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            prev_q <= 1'b1;
        end else begin
            sh     <= feed[STAGES-1:0];
            prev_q <= sh[STAGES-1];
        end
    end

    assign level = sh[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/i2c_reg_bank.sv
// Register bank with a local write port that has priority over the bus port.
module i2c_reg_bank #(
    parameter int NREG  = 4,
    parameter int DW    = 8,
    parameter int PTR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 loc_we,
    input  logic [PTR_W-1:0]     loc_addr,
    input  logic [DW-1:0]        loc_data,
    input  logic                 bus_we,
    input  logic [PTR_W-1:0]     bus_addr,
    input  logic [DW-1:0]        bus_data,
    input  logic [PTR_W-1:0]     rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [NREG*DW-1:0]   regs_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (loc_we && loc_addr == PTR_W'(i)) begin
                q <= loc_data;
            end else if (bus_we && bus_addr == PTR_W'(i)) begin
                q <= bus_data;
            end
        end

        assign regs_flat[i*DW +: DW] = q;
    end

    assign rd_data = regs_flat[rd_addr*DW +: DW];
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Bus protocol controller: condition detection, byte framing, ACK and read shifting.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [DW-1:0]    dev_addr,
    input  logic [DW-1:0]    rd_data,
    output tgt_state_t       st,
    output logic [PTR_W-1:0] ptr,
    output logic             bus_we,
    output logic [DW-1:0]    bus_wdata,
    output logic             start_det,
    output logic             stop_det,
    output logic             sda_pd,
    output logic             sda_pu
);
    localparam int CW = $clog2(DW + 1);

    tgt_state_t    st_nx;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic          rw_q;
    logic          m_ack;
    logic          rx_full;
    logic          addr_hit;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign rx_full   = (bitcnt == CW'(DW));
    // Bit 0 carries the direction and is excluded from the compare.
    assign addr_hit  = ((rx_sh ^ dev_addr) >> 1) == '0;

    // Next-state logic
    always_comb begin
        st_nx = st;
        if (stop_det) begin
            st_nx = ST_IDLE;
        end else if (start_det) begin
            st_nx = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: st_nx = st;
                ST_ADDR:
                    if (scl_fall && rx_full) st_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) st_nx = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:
                    if (scl_fall && rx_full) st_nx = ST_PTR_ACK;
                ST_PTR_ACK:
                    if (scl_fall) st_nx = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && rx_full) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) st_nx = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && bitcnt == CW'(DW - 1)) st_nx = ST_RACK;
                ST_RACK:
                    if (scl_fall) st_nx = m_ack ? ST_RDATA : ST_IGNORE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            m_ack  <= 1'b0;
        end else begin
            st <= st_nx;
            if (start_det) begin
                bitcnt <= '0;
            end else if (!stop_det) begin
                unique case (st)
                    ST_ADDR: begin
                        if (scl_rise && !rx_full) begin
                            rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && rx_full) rw_q <= rx_sh[0];
                    end
                    ST_PTR: begin
                        if (scl_rise && !rx_full) begin
                            rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && rx_full) ptr <= rx_sh[PTR_W-1:0];
                    end
                    ST_WDATA: begin
                        if (scl_rise && !rx_full) begin
                            rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && rx_full) ptr <= ptr + 1'b1;
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR_ACK && rw_q) tx_sh <= rd_data;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            tx_sh  <= tx_sh << 1;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CW'(DW - 1)) ptr <= ptr + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) m_ack <= ~sda_lvl;
                        if (scl_fall) begin
                            bitcnt <= '0;
                            tx_sh  <= rd_data;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bus_we    = (st == ST_WDATA) && scl_fall && rx_full && !start_det && !stop_det;
    assign bus_wdata = rx_sh;

    // Output logic
    always_comb begin
        sda_pd = 1'b0;
        sda_pu = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_pd = 1'b1;
            ST_RDATA: begin
                sda_pd = ~tx_sh[DW-1];
                sda_pu = tx_sh[DW-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int NREG        = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic [DW-1:0]        dev_addr,
    input  logic                 loc_wr,
    input  logic [PTR_W-1:0]     loc_addr,
    input  logic [DW-1:0]        loc_data,
    output logic                 scl_pd,
    output logic                 sda_pd,
    output logic                 sda_pu,
    output logic [NREG*DW-1:0]   reg_q
);
    logic             scl_lvl, scl_rise, scl_fall;
    logic             sda_lvl, sda_rise, sda_fall;
    tgt_state_t       fsm_st;
    logic [PTR_W-1:0] ptr;
    logic             bus_we;
    logic [DW-1:0]    bus_wdata;
    logic [DW-1:0]    rd_data;
    logic             start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_in(scl_in),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_in(sda_in),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    i2c_tgt_fsm #(.DW(DW), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst(rst),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .dev_addr(dev_addr), .rd_data(rd_data),
        .st(fsm_st), .ptr(ptr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pd(sda_pd), .sda_pu(sda_pu)
    );

    i2c_reg_bank #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst(rst),
        .loc_we(loc_wr), .loc_addr(loc_addr), .loc_data(loc_data),
        .bus_we(bus_we), .bus_addr(ptr), .bus_data(bus_wdata),
        .rd_addr(ptr), .rd_data(rd_data), .regs_flat(reg_q)
    );

    // SCL is never stretched.
    assign scl_pd = 1'b0;
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk
    import i2c_tgt_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int DW    = 8,
    parameter int PTR_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               sda_pd,
    input logic               sda_pu,
    input logic               loc_wr,
    input logic [PTR_W-1:0]   loc_addr,
    input logic [DW-1:0]      loc_data,
    input logic [NREG*DW-1:0] reg_q,
    input tgt_state_t         st,
    input logic               stop_det,
    input logic               bus_we,
    input logic [PTR_W-1:0]   ptr
);
    logic             lw_q;
    logic [PTR_W-1:0] la_q;
    logic [DW-1:0]    ld_q;
    logic [DW-1:0]    la_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            lw_q <= 1'b0;
            la_q <= '0;
            ld_q <= '0;
        end else begin
            lw_q <= loc_wr;
            la_q <= loc_addr;
            ld_q <= loc_data;
        end
    end

    assign la_view = reg_q[la_q*DW +: DW];

    p_local_lands_r7: assert property (@(posedge clk) disable iff (rst)
        lw_q |-> la_view == ld_q);

    p_local_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (loc_wr && bus_we && loc_addr == ptr) |=> la_view == ld_q);

    p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
        !(sda_pd && sda_pu));

    p_pullup_in_read_r9: assert property (@(posedge clk) disable iff (rst)
        sda_pu |-> st == ST_RDATA);

    p_ignore_silent_r6: assert property (@(posedge clk) disable iff (rst)
        st == ST_IGNORE |-> (!sda_pd && !sda_pu));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE && !sda_pd && !sda_pu));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> ptr == $past(ptr) + PTR_W'(1));
endmodule

bind i2c_regbank_target i2c_regbank_chk #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .sda_pd(sda_pd), .sda_pu(sda_pu),
    .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_data(loc_data),
    .reg_q(reg_q), .st(fsm_st), .stop_det(stop_det),
    .bus_we(bus_we), .ptr(ptr)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/100ps
module sim_i2c_regbank_target;
    localparam int Q = 50;
    localparam logic [7:0] DEV = 8'h72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl_low = 1'b0;
    logic        m_sda_low = 1'b0;
    logic        loc_wr = 1'b0;
    logic [1:0]  loc_addr = '0;
    logic [7:0]  loc_data = '0;
    logic        scl_pd, sda_pd, sda_pu;
    logic [31:0] reg_q;
    logic        scl_line, sda_line;

    int compared = 0;
    int mismatched = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    int pinned = -1;
    logic [7:0] exp_reg [4];
    int exp_ptr = 0;

    always #2.5 clk = ~clk;

    assign scl_line = ~m_scl_low & ~scl_pd;
    assign sda_line = ~m_sda_low & ~sda_pd;

    i2c_regbank_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .dev_addr(DEV), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_data(loc_data),
        .scl_pd(scl_pd), .sda_pd(sda_pd), .sda_pu(sda_pu), .reg_q(reg_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, 1 ns after each edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk("R9 contention", int'(sda_pd & sda_pu), 0);
            chk("R9 scl_pd", int'(scl_pd), 0);
            if (cmp_en) begin
                for (int r = 0; r < 4; r++) chk("R7 reg_q", int'(reg_q[r*8 +: 8]), int'(exp_reg[r]));
            end
        end
    end

    task automatic bus_start();
        if (m_scl_low) begin
            m_sda_low = 1'b0; #Q;
            m_scl_low = 1'b0; #(2*Q);
        end
        m_sda_low = 1'b1; #(2*Q);
        m_scl_low = 1'b1; #Q;
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; #Q;
        m_scl_low = 1'b0; #(2*Q);
        m_sda_low = 1'b0; #(2*Q);
    endtask

    task automatic tx_bit(input logic b);
        m_sda_low = ~b; #Q;
        m_scl_low = 1'b0; #(2*Q);
        m_scl_low = 1'b1; #Q;
    endtask

    task automatic rx_bit(output logic b);
        m_sda_low = 1'b0; #Q;
        m_scl_low = 1'b0; #Q;
        b = sda_line; #Q;
        m_scl_low = 1'b1; #Q;
    endtask

    task automatic tx_byte(input logic [7:0] v, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
        rx_bit(b);
        acked = ~b;
    endtask

    task automatic rx_byte(output logic [7:0] v, input bit more);
        for (int i = 7; i >= 0; i--) rx_bit(v[i]);
        tx_bit(~more);
    endtask

    task automatic i2c_write(input logic [7:0] pb, input logic [7:0] d [3], input int n);
        bit a;
        bus_start();
        tx_byte(DEV, a);  chk("R2 write address ACK", int'(a), 1);
        tx_byte(pb, a);   chk("R3 pointer ACK", int'(a), 1);
        exp_ptr = pb % 4;
        for (int k = 0; k < n; k++) begin
            cmp_en = 1'b0;
            tx_byte(d[k], a);
            chk("R3 data ACK", int'(a), 1);
            if (exp_ptr != pinned) exp_reg[exp_ptr] = d[k];
            exp_ptr = (exp_ptr + 1) % 4;
            cmp_en = 1'b1;
        end
        bus_stop();
        chk("R10 released after stop", int'({sda_pd, sda_pu}), 0);
    endtask

    task automatic i2c_read(input bit set_ptr, input logic [7:0] pb, input int n);
        bit a;
        logic [7:0] v;
        bus_start();
        if (set_ptr) begin
            tx_byte(DEV, a); chk("R2 address ACK", int'(a), 1);
            tx_byte(pb, a);  chk("R3 pointer ACK", int'(a), 1);
            exp_ptr = pb % 4;
            bus_start();  // repeated START
        end
        tx_byte(DEV | 8'h01, a); chk("R10 read address ACK", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(v, k < n - 1);
            if (set_ptr) chk("R4 read data", int'(v), int'(exp_reg[exp_ptr]));
            else         chk("R5 read continues", int'(v), int'(exp_reg[exp_ptr]));
            exp_ptr = (exp_ptr + 1) % 4;
        end
        chk("R4 released after NACK", int'({sda_pd, sda_pu}), 0);
        bus_stop();
    endtask

    task automatic loc_write(input int a, input logic [7:0] d, input int hold);
        @(negedge clk);
        loc_addr = 2'(a); loc_data = d; loc_wr = 1'b1; cmp_en = 1'b0;
        repeat (hold) @(negedge clk);
        loc_wr = 1'b0; exp_reg[a] = d; cmp_en = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        logic [7:0] d [3];
        bit a;
        for (int r = 0; r < 4; r++) exp_reg[r] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 reg_q at reset", int'(reg_q), 0);
        chk("R1 sda drive at reset", int'({sda_pd, sda_pu}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reg_q after reset", int'(reg_q), 0);
        cmp_en = 1'b1;

        // R7: local writes, the first held for several cycles
        loc_write(0, 8'hDE, 4);
        loc_write(1, 8'hAD, 1);
        loc_write(2, 8'hBE, 2);
        loc_write(3, 8'hEF, 1);
        #(4*Q);

        // R3: single-byte write at pointer 1
        d = '{8'h33, 8'h00, 8'h00};
        i2c_write(8'h01, d, 1);
        #(4*Q);
        // R4: four-byte read from pointer 0, wrapping
        i2c_read(1'b1, 8'h00, 4);
        #(4*Q);
        // R3: three-byte write from 1, wrapping the pointer to 0
        d = '{8'hFA, 8'hCE, 8'h69};
        i2c_write(8'h01, d, 3);
        #(4*Q);
        // R5: pointer carries across transactions
        i2c_read(1'b1, 8'h00, 1);
        i2c_read(1'b0, 8'h00, 1);
        i2c_read(1'b0, 8'h00, 2);
        #(4*Q);

        // R6: foreign address, nothing acknowledged, nothing changes
        bus_start();
        tx_byte(8'hA0, a); chk("R6 foreign address NACK", int'(a), 0);
        tx_byte(8'h01, a); chk("R6 later byte NACK", int'(a), 0);
        tx_byte(8'h55, a); chk("R6 data byte NACK", int'(a), 0);
        bus_stop();
        i2c_read(1'b0, 8'h00, 1);  // R6: pointer unchanged
        #(4*Q);

        // R3: pointer byte 0x06 selects register 2
        d = '{8'h11, 8'h00, 8'h00};
        i2c_write(8'h06, d, 1);
        #(4*Q);

        // R8: local write held on register 3 across a bus write to 3 then 0
        @(negedge clk);
        loc_addr = 2'd3; loc_data = 8'hC3; loc_wr = 1'b1; cmp_en = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_reg[3] = 8'hC3; cmp_en = 1'b1; pinned = 3;
        d = '{8'h5A, 8'h77, 8'h00};
        i2c_write(8'h03, d, 2);
        @(negedge clk);
        loc_wr = 1'b0; pinned = -1;
        repeat (3) @(negedge clk);
        chk("R8 local value kept", int'(reg_q[31:24]), 8'hC3);
        i2c_read(1'b1, 8'h00, 4);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule